// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a single-port synchronous memory built from registers. Its read path is flow-through: a read command registered on one rising edge presents its word during the following cycle. The write path is late: the address, the command and the byte-lane enables of a write are registered on one edge, and the data is taken on the next rising edge. Both operations therefore occupy the data bus exactly one cycle after their command, so reads and writes can be issued back to back in any order with no idle cycles between them.

A built-in burst sequencer lets a host issue one command and then step through up to four neighbouring words. It raises the advance input on each following cycle. While advance is high, the external address, selects and direction are ignored. The operation type last issued (read, write or deselect) is repeated at the next address in linear or interleaved order over the low two address bits. A stall input freezes the whole pipeline, including a write whose data is still due. Three chip selects, an output-enable gate, and a valid flag with a data-out bus take the place of a tri-state data pin.

Top module: `late_write_sram`

## Requirements
- R1: A write command registers its address and lane enables on a non-stalled rising edge; the word on `wdata` is stored at the next non-stalled rising edge.
- R2: A read command registered on a non-stalled edge drives `rdata_vld` high and `rdata` with the stored word during the following cycle (flow-through, no extra register).
- R3: `lane_we_n[i]` low writes bits [9*i+8 : 9*i] of the word; a lane whose enable is high keeps its old contents; all four low write the full 36-bit word.
- R4: Commands may follow one another in any order with no idle cycle; a read issued directly after a write to the same address returns the newly written data.
- R5: With `burst_step` high on a non-stalled edge, `addr`, the chip selects and `rd_not_wr` are ignored; the previous operation type (read, write or deselect) is repeated at the next burst address.
- R6: With `order_ilv` low the low two address bits on the n-th advance are (start + n) mod 4; the upper bits keep the start address.
- R7: With `order_ilv` high the low two address bits on the n-th advance are start XOR (n mod 4).
- R8: While `stall` is high no state changes: the registered command, the burst position and the memory contents are held, a pending write's data is not taken, and the output keeps presenting the current command.
- R9: The block is selected only when `chip_sel_a_n` is low, `chip_sel_b` is high and `chip_sel_c_n` is low; a non-burst command edge with any of them inactive stores nothing and gives `rdata_vld` low and `rdata` zero in the following cycle.
- R10: `out_en_n` high forces `rdata_vld` low and `rdata` to zero at once and has no effect on writes.
- R11: While `rst_n` is low, and after it, the block is deselected: `rdata_vld` is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| stall | input | 1 | High freezes every operation |
| chip_sel_a_n | input | 1 | Chip select, active low |
| chip_sel_b | input | 1 | Chip select, active high |
| chip_sel_c_n | input | 1 | Chip select, active low |
| rd_not_wr | input | 1 | 1 = read, 0 = write |
| burst_step | input | 1 | High continues the previous operation at the next burst address |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| lane_we_n | input | 4 | Active-low write enable per 9-bit lane |
| addr | input | ADDR_W (8) | Word address |
| wdata | input | 36 | Write data, one cycle after its command |
| out_en_n | input | 1 | Active-low read output enable |
| rdata | output | 36 | Read data, zero when not valid |
| rdata_vld | output | 1 | High when `rdata` carries a read word |

## Verification
The bench targets a read that immediately follows a write to the same address. A design that stored write data on the command edge, or two edges late, would return the old word there. It stalls in the middle of a burst and in the cycle where write data is due: a design that let the stall through would skip a burst address or take the wrong data word. Burst steps run across the wrap of the low two bits in both orders, so a counter that carried into the upper address bits, or used addition in interleaved mode, reads the wrong location. Each chip select and the output enable are dropped in turn, including during a write, so gating that was too broad (blocking writes) or too narrow (one select ignored) shows up as a mismatch in `rdata_vld`.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits of a burst step: linear adds, interleaved flips.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/lw_burst_seq.sv
module lw_burst_seq
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              step,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cmd_addr
);

  logic [ADDR_W-1:0] start_q;
  logic [1:0]        pos_q;
  logic [1:0]        pos_nxt;

  assign pos_nxt  = pos_q + 2'd1;
  assign cmd_addr = step ? {start_q[ADDR_W-1:2], burst_low(start_q[1:0], pos_nxt, ilv)}
                         : ext_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      pos_q   <= '0;
    end else if (!stall) begin
      if (step) begin
        pos_q <= pos_nxt;
      end else begin
        start_q <= ext_addr;
        pos_q   <= '0;
      end
    end
  end

  // R5: every advance moves the burst position by one.
  a_r5_pos_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && step) |=> (pos_q == $past(pos_q) + 2'd1));

  // R8: a stall holds the burst position and start address.
  a_r8_burst_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pos_q) && $stable(start_q)));

  // R6 / R7: burst addresses never leave the aligned group of four.
  a_r6_r7_same_group: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cmd_addr[ADDR_W-1:2] == start_q[ADDR_W-1:2]));

endmodule

// File: rtl/lw_cmd_reg.sv
module lw_cmd_reg
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              step,
  input  logic              sel_ok,
  input  logic              rd_not_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  lane_we_n,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  lane_q
);

  op_e op_nxt;

  always_comb begin
    if (step)           op_nxt = op_q;
    else if (!sel_ok)   op_nxt = OP_IDLE;
    else if (rd_not_wr) op_nxt = OP_READ;
    else                op_nxt = OP_WRITE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      lane_q <= '1;
    end else if (!stall) begin
      op_q   <= op_nxt;
      addr_q <= cmd_addr;
      lane_q <= lane_we_n;
    end
  end

  // R8: nothing registered moves while stalled.
  a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(op_q) && $stable(addr_q) && $stable(lane_q)));

  // R5: an advance repeats the previous operation type.
  a_r5_repeat_op: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && step) |=> (op_q == $past(op_q)));

  // R9: a deselected command edge leaves the block idle.
  a_r9_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !step && !sel_ok) |=> (op_q == OP_IDLE));

endmodule

// File: rtl/lw_lane_mem.sv
module lw_lane_mem #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_fire,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [LANES*LANE_W-1:0] wr_word,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_fire && !lane_en_n[g]) begin
        store[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
      end
    end

    assign rd_word[g*LANE_W +: LANE_W] = store[rd_addr];
  end

endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic                    chip_sel_a_n,
  input  logic                    chip_sel_b,
  input  logic                    chip_sel_c_n,
  input  logic                    rd_not_wr,
  input  logic                    burst_step,
  input  logic                    order_ilv,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_vld
);

  localparam int DATA_W = LANES * LANE_W;

  logic              sel_ok;
  logic [ADDR_W-1:0] cmd_addr;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lane_q;
  logic              wr_fire;
  logic [DATA_W-1:0] rd_word;

  assign sel_ok = !chip_sel_a_n && chip_sel_b && !chip_sel_c_n;

  lw_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .step     (burst_step),
    .ilv      (order_ilv),
    .ext_addr (addr),
    .cmd_addr (cmd_addr)
  );

  lw_cmd_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .step      (burst_step),
    .sel_ok    (sel_ok),
    .rd_not_wr (rd_not_wr),
    .cmd_addr  (cmd_addr),
    .lane_we_n (lane_we_n),
    .op_q      (op_q),
    .addr_q    (addr_q),
    .lane_q    (lane_q)
  );

  // Late write: data of the registered write command lands on this edge.
  assign wr_fire = (op_q == OP_WRITE) && !stall;

  lw_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk       (clk),
    .wr_fire   (wr_fire),
    .wr_addr   (addr_q),
    .lane_en_n (lane_q),
    .wr_word   (wdata),
    .rd_addr   (addr_q),
    .rd_word   (rd_word)
  );

  // Flow-through read: the stored word of the registered read goes straight out.
  assign rdata_vld = (op_q == OP_READ) && !out_en_n;
  assign rdata     = rdata_vld ? rd_word : '0;

  // R10: a disabled output never claims valid data.
  a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!rdata_vld && (rdata == '0)));

  // R2: a selected read command is presented in the following cycle.
  a_r2_read_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !burst_step && sel_ok && rd_not_wr) |=> (rdata_vld || out_en_n));

  // R1: data is taken only for a registered write on an unstalled edge.
  a_r1_fire_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (!stall && !rdata_vld));

endmodule

// File: tb/sim_late_write_sram.sv
`timescale 1ns/1ps
module sim_late_write_sram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        chip_sel_a_n = 1'b1;
  logic        chip_sel_b = 1'b0;
  logic        chip_sel_c_n = 1'b1;
  logic        rd_not_wr = 1'b1;
  logic        burst_step = 1'b0;
  logic        order_ilv = 1'b0;
  logic [3:0]  lane_we_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic        out_en_n = 1'b0;
  logic [35:0] rdata;
  logic        rdata_vld;

  always #2 clk = ~clk;

  late_write_sram u0 (.*);

  // Behavioural reference model: 0 idle, 1 read, 2 write.
  int          m_op = 0;
  logic [7:0]  m_addr = '0;
  logic [7:0]  m_start = '0;
  int          m_pos = 0;
  logic [3:0]  m_lanes = 4'hF;
  logic [35:0] m_mem [256];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  task automatic model_edge();
    int lo;
    if (!rst_n) begin
      m_op = 0; m_addr = '0; m_start = '0; m_pos = 0; m_lanes = 4'hF;
      return;
    end
    if (stall) return;
    if (m_op == 2)
      for (int i = 0; i < 4; i++)
        if (!m_lanes[i]) m_mem[m_addr][i*9 +: 9] = wdata[i*9 +: 9];
    if (burst_step) begin
      m_pos = (m_pos + 1) % 4;
      if (order_ilv) lo = int'(m_start[1:0]) ^ m_pos;
      else           lo = (int'(m_start[1:0]) + m_pos) % 4;
      m_addr = {m_start[7:2], lo[1:0]};
    end else begin
      if (!chip_sel_a_n && chip_sel_b && !chip_sel_c_n) m_op = rd_not_wr ? 1 : 2;
      else m_op = 0;
      m_addr = addr; m_start = addr; m_pos = 0;
    end
    m_lanes = lane_we_n;
  endtask

  task automatic check_out(string tag);
    logic        ev;
    logic [35:0] ed;
    ev = (m_op == 1) && !out_en_n;
    ed = ev ? m_mem[m_addr] : 36'd0;
    n_checks++;
    if (rdata_vld !== ev || rdata !== ed) begin
      n_fail++;
      $display("FAIL %s: vld=%b data=%h expected vld=%b data=%h (addr %0d)",
               tag, rdata_vld, rdata, ev, ed, m_addr);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    #1;
    check_out(tag);
    @(negedge clk);
    wdata = {$urandom, $urandom} [35:0];
  endtask

  task automatic sel(bit on);
    chip_sel_a_n = !on; chip_sel_b = on; chip_sel_c_n = !on;
  endtask

  task automatic cmd(bit rd, logic [7:0] a, logic [3:0] be, string tag);
    stall = 0; burst_step = 0; sel(1); rd_not_wr = rd; addr = a; lane_we_n = be;
    tick(tag);
  endtask

  task automatic adv(bit ilv, string tag);
    // Junk on the ignored inputs.
    stall = 0; burst_step = 1; order_ilv = ilv; addr = 8'($urandom);
    chip_sel_a_n = 1'($urandom); chip_sel_b = 1'($urandom); chip_sel_c_n = 1'($urandom);
    rd_not_wr = 1'($urandom); lane_we_n = 4'h0;
    tick(tag);
  endtask

  task automatic hold(string tag);
    stall = 1; addr = 8'($urandom); rd_not_wr = 1'($urandom);
    tick(tag);
    stall = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    @(negedge clk);
    tick("R11 in reset");
    tick("R11 in reset");
    rst_n = 1'b1;
    tick("R11 after reset");

    // R1: back-to-back full-word writes fill the whole array.
    for (int a = 0; a < 256; a++) cmd(0, 8'(a), 4'h0, "R1 fill");
    // R2: back-to-back reads of every word.
    for (int a = 0; a < 256; a++) cmd(1, 8'(a), 4'h0, "R2 read");

    // R4: alternating write/read on the same address, no idle cycles.
    for (int k = 0; k < 16; k++) begin
      cmd(0, 8'(k * 7), 4'h0, "R4 write");
      cmd(1, 8'(k * 7), 4'h0, "R4 read after write");
    end

    // R3: single lanes and pairs.
    for (int k = 0; k < 16; k++) begin
      cmd(0, 8'(40 + k), 4'(k), "R3 lane write");
      cmd(1, 8'(40 + k), 4'hF, "R3 lane read");
    end

    // R5 / R6: linear bursts of write then read across the wrap.
    for (int s = 0; s < 4; s++) begin
      order_ilv = 0;
      cmd(0, 8'(100 + s), 4'h0, "R6 burst write start");
      for (int n = 0; n < 5; n++) adv(0, "R6 linear write step");
      cmd(1, 8'(100 + s), 4'h0, "R5 burst read start");
      for (int n = 0; n < 5; n++) adv(0, "R6 linear read step");
    end
    // R7: interleaved order.
    for (int s = 0; s < 4; s++) begin
      cmd(0, 8'(120 + s), 4'h0, "R7 burst write start");
      for (int n = 0; n < 3; n++) adv(1, "R7 interleaved write step");
      cmd(1, 8'(120 + s), 4'h0, "R7 burst read start");
      for (int n = 0; n < 5; n++) adv(1, "R7 interleaved read step");
    end
    // R5: a deselect repeated by the burst stays idle.
    sel(0); burst_step = 0; tick("R5 deselect start");
    for (int n = 0; n < 3; n++) adv(0, "R5 deselect burst");

    // R8: stall during pending write data and in mid burst.
    cmd(0, 8'd200, 4'h0, "R8 write cmd");
    hold("R8 stall pending write");
    hold("R8 stall pending write");
    cmd(1, 8'd200, 4'h0, "R8 read after stalled write");
    cmd(1, 8'd204, 4'h0, "R8 burst start");
    adv(0, "R8 burst step");
    hold("R8 stall mid burst");
    adv(0, "R8 burst resumes");
    adv(1, "R8 burst resumes");

    // R9: each select alone blocks both reads and writes.
    for (int w = 0; w < 3; w++) begin
      stall = 0; burst_step = 0; sel(1); rd_not_wr = 0; addr = 8'd210; lane_we_n = 4'h0;
      if (w == 0) chip_sel_a_n = 1; else if (w == 1) chip_sel_b = 0; else chip_sel_c_n = 1;
      tick("R9 deselected write");
      rd_not_wr = 1;
      tick("R9 deselected read");
      cmd(1, 8'd210, 4'h0, "R9 word unchanged");
    end

    // R10: output enable high during a read and during a write.
    out_en_n = 1;
    cmd(1, 8'd5, 4'h0, "R10 read gated");
    cmd(0, 8'd5, 4'h0, "R10 write with oe high");
    cmd(1, 8'd5, 4'h0, "R10 read gated");
    out_en_n = 0;
    cmd(1, 8'd5, 4'h0, "R10 written word visible");

    // R4: random mix of every input.
    for (int k = 0; k < 3000; k++) begin
      stall = ($urandom % 8) == 0;
      burst_step = ($urandom % 3) == 0;
      order_ilv = 1'($urandom);
      sel(($urandom % 6) != 0);
      rd_not_wr = 1'($urandom);
      addr = 8'($urandom % 32);
      lane_we_n = 4'($urandom);
      out_en_n = ($urandom % 10) == 0;
      tick("R4 random mix");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule